// File: doc/BRIEF.md
# Cross-Domain Synchronized Control Register

This block is an 8-bit control register written from a bus clock domain. Two of its fields, an enable and a software reset, take effect in a separate peripheral clock domain. A third field, a clock-source select, acts at once from the bus side. A bus write to either synchronized field starts a toggle request towards the peripheral domain and sets a busy flag. The flag stays set until the peripheral domain has applied the change and its acknowledge has come back through a synchronizer.

A write that requests a software reset takes priority over every other field in the same access. While a reset is in flight, the register accepts no further writes. When the reset completes, every bus-side field returns to zero in the same cycle that the reset busy flag drops. On the same event the peripheral domain drives its enable low and emits a one-cycle reset pulse. A separate read-only address reports the busy flags. A write-protect input blocks all writes and leaves reads unaffected.

Top module: `csr_xdom`

## Requirements
- R1: The control address is 0. On a read, bit 0 shows the reset-busy state, bit 1 the stored enable and bit 4 the clock select. Every other bit reads 0, and after reset the register reads 0x00.
- R2: An accepted control write with bit 0 = 1 starts a software reset and discards its enable and clock-select fields. A write with bit 0 = 0 starts no reset.
- R3: An accepted write that is not a reset request and arrives while no enable transfer is pending updates the stored enable, which reads back in the next bus cycle. The same write sets the enable busy flag.
- R4: `per_enable` keeps its old value for at least two peripheral clock edges after the write. It holds the new value by the time the enable busy flag clears.
- R5: The clock select (bit 4) updates `pclk_sel` one bus cycle after any accepted non-reset write. It has no busy flag.
- R6: Reset bit 0 and status bit 0 stay 1 until the reset completes. At completion both clear together with all stored fields. `per_enable` is then 0, and `per_swrst` has pulsed for one peripheral cycle.
- R7: The enable field of a write made while the enable busy flag is set is ignored. While a reset is pending, every control write is ignored.
- R8: While `wprot` is 1, writes change nothing, and reads return the stored values.
- R9: The status address is 1. Bit 0 is reset busy, bit 1 is enable busy, and the other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Bus-domain synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wprot | input | 1 | Write protect; blocks all writes |
| addr | input | ADDR_W | Register address (0 control, 1 status) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| pclk_sel | output | 1 | Clock-source select (0 general clock, 1 low-power 32 kHz clock) |
| pclk | input | 1 | Peripheral clock |
| per_rst_n | input | 1 | Peripheral-domain synchronous active-low reset |
| per_enable | output | 1 | Enable as applied in the peripheral domain |
| per_swrst | output | 1 | One-cycle software-reset pulse in the peripheral domain |

## Verification
Assertions check the following on every cycle: no transfer restarts while its busy flag is set, each request arrives as a single-cycle pulse, and the stored enable holds still while its transfer is in flight. They also check that reset requests, protected writes and accepted writes leave the clock select and enable exactly as the rules say, and that an arriving reset drops `per_enable` and pulses `per_swrst`. Only the bench scenarios can show the timing across the two clocks. These are that `per_enable` lags the write by the synchronizer delay, that busy flags fall only once the peripheral has applied the change, and that the reset-versus-enable priority and the blocking of writes during a pending reset hold.

// File: rtl/csr_xdom_pkg.sv
// Package: shared constants for the cross-domain control register.
// Assumes an 8-bit register; field positions are fixed by software decode.
package csr_xdom_pkg;
    localparam int unsigned REG_W    = 8;
    localparam int unsigned BIT_RST  = 0;
    localparam int unsigned BIT_EN   = 1;
    localparam int unsigned BIT_SEL  = 4;
    localparam int unsigned NFIELD   = 2;   // synchronized fields
    localparam int unsigned FLD_RST  = 0;   // channel index = status bit
    localparam int unsigned FLD_EN   = 1;
    localparam int unsigned ADR_CTRL = 0;
    localparam int unsigned ADR_STAT = 1;
endpackage

// File: rtl/xdom_sync.sv
// Module: multi-flop synchronizer for a single slowly changing bit.
// Assumes the input is a level or toggle held long enough to be sampled.
module xdom_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    // Shift the asynchronous input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/xfer_chan.sv
// Module: toggle request/acknowledge channel between the bus and peripheral clocks.
// Bus side: 'start' flips the request and sets 'busy'; 'done' pulses when the
// acknowledge returns. Peripheral side: 'arrive' pulses once per request, and the
// acknowledge follows on the edge where the peripheral applies the change.
// Assumes both domain resets are asserted together and 'start' only when idle.
module xfer_chan #(
    parameter int unsigned STAGES = 2
) (
    input  logic bclk,
    input  logic bus_rst_n,
    input  logic start,
    output logic busy,
    output logic done,
    input  logic pclk,
    input  logic per_rst_n,
    output logic arrive
);
    logic req_tog, ack_s, req_s, seen;

    // Flip the request toggle once per started transfer.
    always_ff @(posedge bclk) begin
        if (!bus_rst_n)  req_tog <= 1'b0;
        else if (start)  req_tog <= ~req_tog;
    end

    // Hold busy from start until the acknowledge matches the request.
    always_ff @(posedge bclk) begin
        if (!bus_rst_n)  busy <= 1'b0;
        else if (start)  busy <= 1'b1;
        else if (done)   busy <= 1'b0;
    end

    assign done = busy && (ack_s == req_tog);

    xdom_sync #(.STAGES(STAGES)) u_req (
        .clk(pclk), .rst_n(per_rst_n), .d(req_tog), .q(req_s)
    );

    // Remember the last request level seen in the peripheral domain.
    always_ff @(posedge pclk) begin
        if (!per_rst_n) seen <= 1'b0;
        else            seen <= req_s;
    end

    assign arrive = req_s ^ seen;

    xdom_sync #(.STAGES(STAGES)) u_ack (
        .clk(bclk), .rst_n(bus_rst_n), .d(seen), .q(ack_s)
    );

    p_start_idle_r7: assert property (@(posedge bclk) disable iff (!bus_rst_n)
        start |-> !busy);
    p_busy_set_r3: assert property (@(posedge bclk) disable iff (!bus_rst_n)
        start |=> busy);
    p_arrive_once_r4: assert property (@(posedge pclk) disable iff (!per_rst_n)
        arrive |=> !arrive);
endmodule

// File: rtl/csr_xdom.sv
// Module: control register with synchronized enable and software reset.
// Bus-side fields live in the bus clock domain. Enable and reset are handed to the
// peripheral domain through one toggle channel each. The stored enable is held
// stable while its transfer is pending, so the peripheral may sample it directly.
// Assumes both resets are asserted together and wr_en lasts one bus cycle.
module csr_xdom
    import csr_xdom_pkg::*;
#(
    parameter int unsigned ADDR_W = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic              bclk,
    input  logic              bus_rst_n,
    input  logic              wr_en,
    input  logic              wprot,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output logic              pclk_sel,
    input  logic              pclk,
    input  logic              per_rst_n,
    output logic              per_enable,
    output logic              per_swrst
);
    logic [NFIELD-1:0] start_v, busy_v, done_v, arrive_v;
    logic acc, rst_req, en_shadow;
    logic unused_bits;

    assign unused_bits = ^{wdata[7:5], wdata[3:2]};

    // A control write is accepted when unprotected and no reset is pending.
    assign acc     = wr_en && !wprot && (addr == ADDR_W'(ADR_CTRL)) && !busy_v[FLD_RST];
    assign rst_req = acc && wdata[BIT_RST];
    assign start_v[FLD_RST] = rst_req;
    assign start_v[FLD_EN]  = acc && !wdata[BIT_RST] && !busy_v[FLD_EN];

    genvar gi;
    generate
        for (gi = 0; gi < NFIELD; gi++) begin : g_chan
            xfer_chan #(.STAGES(STAGES)) u_chan (
                .bclk(bclk), .bus_rst_n(bus_rst_n), .start(start_v[gi]),
                .busy(busy_v[gi]), .done(done_v[gi]),
                .pclk(pclk), .per_rst_n(per_rst_n), .arrive(arrive_v[gi])
            );
        end
    endgenerate

    // Bus-side fields: cleared on reset completion, else loaded by accepted writes.
    always_ff @(posedge bclk) begin
        if (!bus_rst_n || done_v[FLD_RST]) begin
            en_shadow <= 1'b0;
            pclk_sel  <= 1'b0;
        end else if (acc && !wdata[BIT_RST]) begin
            pclk_sel <= wdata[BIT_SEL];
            if (start_v[FLD_EN]) en_shadow <= wdata[BIT_EN];
        end
    end

    // Read mux for the control and status addresses.
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(ADR_CTRL)) begin
            rdata[BIT_RST] = busy_v[FLD_RST];
            rdata[BIT_EN]  = en_shadow;
            rdata[BIT_SEL] = pclk_sel;
        end else if (addr == ADDR_W'(ADR_STAT)) begin
            rdata[NFIELD-1:0] = busy_v;
        end
    end

    // Peripheral enable: reset arrival wins, otherwise take the held enable value.
    always_ff @(posedge pclk) begin
        if (!per_rst_n)                per_enable <= 1'b0;
        else if (arrive_v[FLD_RST])    per_enable <= 1'b0;
        else if (arrive_v[FLD_EN])     per_enable <= en_shadow;
    end

    // One-cycle software reset pulse in the peripheral domain.
    always_ff @(posedge pclk) begin
        if (!per_rst_n) per_swrst <= 1'b0;
        else            per_swrst <= arrive_v[FLD_RST];
    end

    p_rst_wins_r2: assert property (@(posedge bclk) disable iff (!bus_rst_n)
        rst_req |=> (en_shadow == $past(en_shadow)) && (pclk_sel == $past(pclk_sel)));
    p_sel_direct_r5: assert property (@(posedge bclk) disable iff (!bus_rst_n)
        (acc && !wdata[BIT_RST]) |=> (pclk_sel == $past(wdata[BIT_SEL])));
    p_wprot_r8: assert property (@(posedge bclk) disable iff (!bus_rst_n)
        (wr_en && wprot && !busy_v[FLD_RST]) |=> $stable(pclk_sel) && $stable(en_shadow));
    p_en_hold_r4: assert property (@(posedge bclk) disable iff (!bus_rst_n)
        (busy_v[FLD_EN] && !done_v[FLD_RST]) |=> (en_shadow == $past(en_shadow)));
    p_rst_done_r6: assert property (@(posedge bclk) disable iff (!bus_rst_n)
        done_v[FLD_RST] |=> !busy_v[FLD_RST] && !en_shadow && !pclk_sel);
    p_rst_applies_r6: assert property (@(posedge pclk) disable iff (!per_rst_n)
        arrive_v[FLD_RST] |=> !per_enable && per_swrst);
endmodule

// File: tb/csr_xdom_test.sv
// Bench: behavioural model of the bus-visible fields, compared every bus cycle,
// plus scenario checks on the cross-domain timing. Clocks are unrelated.
module csr_xdom_test;
    logic bclk = 1'b0, pclk = 1'b0;
    logic bus_rst_n = 1'b0, per_rst_n = 1'b0;
    logic wr_en = 1'b0, wprot = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00, rdata;
    logic pclk_sel, per_enable, per_swrst;

    always #5    bclk = ~bclk;
    always #18.5 pclk = ~pclk;

    csr_xdom uut (
        .bclk(bclk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wprot(wprot),
        .addr(addr), .wdata(wdata), .rdata(rdata), .pclk_sel(pclk_sel),
        .pclk(pclk), .per_rst_n(per_rst_n), .per_enable(per_enable),
        .per_swrst(per_swrst)
    );

    int n_chk = 0, n_bad = 0;
    bit m_live = 0, m_en = 0, m_sel = 0, m_en_p = 0, m_rst_p = 0;
    bit swrst_seen = 0, finished = 0;

    task automatic chk(input string r, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Record any peripheral reset pulse.
    always @(posedge pclk) begin
        #1;
        if (per_swrst) swrst_seen = 1;
    end

    // Compare bus-visible fields against the model on every bus cycle.
    always @(posedge bclk) begin
        #2;
        if (m_live && !m_rst_p && !finished) begin
            chk("R5 pclk_sel model", pclk_sel, m_sel);
            if (addr == 2'd0) begin
                chk("R3 ctrl enable model", rdata[1], m_en);
                chk("R1 ctrl reset bit model", rdata[0], 0);
            end
        end
    end

    task automatic wr(input logic [7:0] d, input bit prot);
        @(negedge bclk);
        addr = 2'd0; wdata = d; wprot = prot; wr_en = 1'b1;
        if (!prot && !m_rst_p) begin
            if (d[0]) begin
                m_rst_p = 1; swrst_seen = 0;
            end else begin
                m_sel = d[4];
                if (!m_en_p) begin m_en = d[1]; m_en_p = 1; end
            end
        end
        @(negedge bclk);
        wr_en = 1'b0; wprot = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        addr = a; #1; v = rdata; addr = 2'd0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        addr = 2'd1;
        forever begin
            @(negedge bclk);
            n++;
            if (rdata[1:0] == 2'b00 || n > 400) break;
        end
        chk("R4 busy flags clear", int'(n <= 400), 1);
        if (m_rst_p) begin
            chk("R6 per_enable off after reset", per_enable, 0);
            chk("R6 reset pulse seen", swrst_seen, 1);
            chk("R6 clock select cleared", pclk_sel, 0);
            m_en = 0; m_sel = 0; m_en_p = 0; m_rst_p = 0;
        end else if (m_en_p) begin
            chk("R4 enable applied before busy clears", per_enable, m_en);
            m_en_p = 0;
        end
        addr = 2'd0;
    endtask

    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (6) @(negedge pclk);
        @(negedge bclk);
        bus_rst_n = 1'b1; per_rst_n = 1'b1;
        m_live = 1;
        // R1 reset state
        rd(2'd0, v); chk("R1 ctrl reset value", v, 8'h00);
        rd(2'd1, v); chk("R9 status reset value", v, 8'h00);
        chk("R1 per_enable at reset", per_enable, 0);

        // R3/R4 enable on
        wr(8'h02, 0);
        rd(2'd0, v); chk("R3 enable reads back", v, 8'h02);
        rd(2'd1, v); chk("R9 R3 enable busy set", v, 8'h02);
        chk("R4 per_enable not yet", per_enable, 0);
        #50;
        chk("R4 per_enable held through sync", per_enable, 0);
        wait_idle(n);
        chk("R4 handshake latency", int'(n >= 3), 1);

        // R5/R7 select during enable busy
        wr(8'h10, 0);
        wr(8'h02, 0);
        chk("R5 select follows second write", pclk_sel, 0);
        rd(2'd0, v); chk("R7 enable ignored while busy", v, 8'h00);
        wait_idle(n);
        chk("R7 per_enable from first write", per_enable, 0);

        // R8 write protect
        wr(8'h12, 1);
        rd(2'd0, v); chk("R8 protected write ignored", v, 8'h00);
        rd(2'd1, v); chk("R8 no busy after protected write", v, 8'h00);

        // R1 reserved bits
        wr(8'hEE, 0);
        rd(2'd0, v); chk("R1 reserved bits read zero", v, 8'h02);
        wait_idle(n);

        // R2/R6/R7 reset priority
        wr(8'h12, 0);
        wait_idle(n);
        chk("R4 enabled before reset", per_enable, 1);
        wr(8'h01, 0);
        rd(2'd0, v); chk("R2 reset discards other fields", v, 8'h13);
        rd(2'd1, v); chk("R9 R6 reset busy only", v, 8'h01);
        wr(8'h00, 0);
        rd(2'd0, v); chk("R7 write ignored during reset", v, 8'h13);
        chk("R7 select held during reset", pclk_sel, 1);
        wait_idle(n);
        rd(2'd0, v); chk("R6 register cleared", v, 8'h00);

        // R2 writing zero to reset bit
        wr(8'h00, 0);
        rd(2'd1, v); chk("R2 zero starts no reset", v, 8'h02);
        wait_idle(n);

        // R4 disable latency
        wr(8'h02, 0);
        wait_idle(n);
        wr(8'h00, 0);
        #50;
        chk("R4 disable held through sync", per_enable, 1);
        wait_idle(n);
        chk("R4 disabled after handshake", per_enable, 0);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule